// File: doc/BRIEF.md
# Cascaded Reversible-Style Arithmetic Logic Unit with Signed Flags

This block is a purely combinational n-bit arithmetic logic unit, WIDTH bits wide (default 4). It is built as a ripple of identical one-bit slices. Each slice makes four candidate values in parallel, then steers one of them onto its result line. The candidates are AND, OR, the sum bit of a full adder, and XOR. The steering code is formed by sel2 (high bit) and sel1 (low bit).

The second operand enters each slice as Y' = Y xor as_ctl. With as_ctl high, the logic candidates therefore work on an inverted Y, and the adder subtracts when cin is also high. With cpn high, the AND and OR candidates are inverted, which gives NAND and NOR.

The slices pass the control signals along the chain from one to the next, so no control signal fans out. Every output line has a matching input line. Zero ancilla inputs seed the AND, OR and result lines of each slice, and two more seed the overflow and set-less-than flags at the most significant position. Unselected candidates leave the block as garbage lines. Four XOR taps produce the two flags: two for signed overflow and two for set-less-than.

Top module: `ralu_chain`

## Requirements
- R1: Each bit i of result carries the candidate picked by code {sel2,sel1}. Code 0 picks X&Y', code 1 picks X|Y', code 2 picks the arithmetic sum bit, and code 3 picks X^Y'. Here Y' = Y xor as_ctl.
- R2: When cpn is 1, the AND and OR candidates are inverted (NAND/NOR). The sum and XOR candidates do not depend on cpn.
- R3: The arithmetic candidates form X + Y' + cin modulo 2^WIDTH. cout is the carry out of bit WIDTH-1. With as_ctl=1 and cin=1 this is X-Y.
- R4: ovf equals anc_flag[0] xor (carry into the top slice) xor (carry out of it). With zero ancillas this is the two's-complement overflow of the sum.
- R5: slt equals anc_flag[1] xor (top bit of the arithmetic sum) xor ovf. With zero ancillas, as_ctl=1 and cin=1, it is 1 exactly when X < Y as signed numbers.
- R6: as_out, cpn_out, sel1_out and sel2_out equal the matching inputs after travelling through every slice.
- R7: x_out equals x.
- R8: Bits garb[3i+2:3i] hold the three candidates of bit i that were not selected, in ascending code order, lowest code at 3i.
- R9: A 1 on anc_fn[3i] inverts the AND candidate of bit i. A 1 on anc_fn[3i+1] inverts the OR candidate of bit i. A 1 on anc_fn[3i+2] inverts result[i] only, and leaves the garbage lines unchanged.
- R10: The number of input bits equals the number of output bits, namely 5*WIDTH+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| as_ctl | input | 1 | Invert Y / subtract select |
| cin | input | 1 | Carry into bit 0 |
| cpn | input | 1 | Invert AND/OR candidates |
| sel1 | input | 1 | Function code low bit |
| sel2 | input | 1 | Function code high bit |
| anc_fn | input | 3*WIDTH | Per-bit zero ancillas (AND, OR, result seeds) |
| anc_flag | input | 2 | Zero ancillas for ovf (bit 0) and slt (bit 1) |
| result | output | WIDTH | Selected function word |
| cout | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow flag |
| slt | output | 1 | Signed set-less-than flag |
| as_out | output | 1 | as_ctl after the last slice |
| cpn_out | output | 1 | cpn after the last slice |
| sel1_out | output | 1 | sel1 after the last slice |
| sel2_out | output | 1 | sel2 after the last slice |
| x_out | output | WIDTH | Copy of x |
| garb | output | 3*WIDTH | Unselected candidates per bit |

## Verification
The embedded assertions check several properties whenever the inputs change:
- each slice's carry is the majority of its three inputs;
- the XOR code routes X^Y' to the result;
- cpn turns AND into NAND;
- the arithmetic code routes the sum word out;
- the overflow flag agrees with the sign pattern of the top operands and the sum;
- the control copies leave the chain intact.

Only the bench's scenarios can show that the flags match signed comparison and signed range over every operand pair. The same holds for the ordering of the garbage lines, for the effect of set ancillas, and for the line-count balance.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
    typedef enum logic [1:0] {
        FN_AND   = 2'd0,
        FN_OR    = 2'd1,
        FN_ARITH = 2'd2,
        FN_XOR   = 2'd3
    } fn_code_t;

    localparam int SLICE_ANC = 3;
    localparam int FLAG_ANC  = 2;
    localparam int FN_COUNT  = 4;
endpackage

// File: rtl/ralu_fgen.sv
module ralu_fgen
    import ralu_pkg::*;
(
    input  logic                as_i,
    input  logic                cpn_i,
    input  logic                x_i,
    input  logic                y_i,
    input  logic                cin_i,
    input  logic [1:0]          seed_i,
    output logic [FN_COUNT-1:0] fn_o,
    output logic                cout_o
);
    logic yp, prop_and, half;

    always_comb begin
        yp       = y_i ^ as_i;
        prop_and = x_i & yp;
        half     = x_i ^ yp;
        fn_o[FN_AND]   = prop_and ^ cpn_i ^ seed_i[0];
        fn_o[FN_OR]    = half ^ prop_and ^ cpn_i ^ seed_i[1];
        fn_o[FN_ARITH] = half ^ cin_i;
        fn_o[FN_XOR]   = half;
        cout_o         = prop_and ^ (cin_i & half);
    end

    always_comb begin
        assert_carry_majority_R3: assert (cout_o ==
            ((x_i & (y_i ^ as_i)) | (x_i & cin_i) | ((y_i ^ as_i) & cin_i)))
            else $error("slice carry is not the majority of its inputs");
        if (cpn_i && !seed_i[0])
            assert_nand_R2: assert (fn_o[FN_AND] == !(x_i && (y_i != as_i)))
                else $error("cpn did not give NAND");
    end
endmodule

// File: rtl/ralu_fsel.sv
module ralu_fsel
    import ralu_pkg::*;
(
    input  logic [FN_COUNT-1:0] fn_i,
    input  logic                sel1_i,
    input  logic                sel2_i,
    input  logic                seed_i,
    output logic                res_o,
    output logic [2:0]          garb_o
);
    fn_code_t code;
    logic     pick;

    always_comb begin
        code = fn_code_t'({sel2_i, sel1_i});
        unique case (code)
            FN_AND:   pick = fn_i[0];
            FN_OR:    pick = fn_i[1];
            FN_ARITH: pick = fn_i[2];
            FN_XOR:   pick = fn_i[3];
            default:  pick = 1'b0;
        endcase
        res_o = pick ^ seed_i;
    end

    for (genvar k = 0; k < 3; k++) begin : g_garb
        assign garb_o[k] = (int'(code) <= k) ? fn_i[k+1] : fn_i[k];
    end
endmodule

// File: rtl/ralu_slice.sv
module ralu_slice
    import ralu_pkg::*;
(
    input  logic                 as_i,
    input  logic                 cpn_i,
    input  logic                 sel1_i,
    input  logic                 sel2_i,
    input  logic                 x_i,
    input  logic                 y_i,
    input  logic                 cin_i,
    input  logic [SLICE_ANC-1:0] anc_i,
    output logic                 as_o,
    output logic                 cpn_o,
    output logic                 sel1_o,
    output logic                 sel2_o,
    output logic                 x_o,
    output logic                 cout_o,
    output logic                 sum_o,
    output logic                 res_o,
    output logic [2:0]           garb_o
);
    logic [FN_COUNT-1:0] fn;

    ralu_fgen u_fgen (
        .as_i(as_i), .cpn_i(cpn_i), .x_i(x_i), .y_i(y_i), .cin_i(cin_i),
        .seed_i(anc_i[1:0]), .fn_o(fn), .cout_o(cout_o)
    );

    ralu_fsel u_fsel (
        .fn_i(fn), .sel1_i(sel1_i), .sel2_i(sel2_i), .seed_i(anc_i[2]),
        .res_o(res_o), .garb_o(garb_o)
    );

    assign as_o   = as_i;
    assign cpn_o  = cpn_i;
    assign sel1_o = sel1_i;
    assign sel2_o = sel2_i;
    assign x_o    = x_i;
    assign sum_o  = fn[FN_ARITH];

    always_comb begin
        if (anc_i == '0 && sel1_i && sel2_i)
            assert_xor_select_R1: assert (res_o == (x_i ^ y_i ^ as_i))
                else $error("xor code did not route X^Y'");
    end
endmodule

// File: rtl/ralu_flags.sv
module ralu_flags
    import ralu_pkg::*;
(
    input  logic                carry_msb_in_i,
    input  logic                carry_msb_out_i,
    input  logic                sign_i,
    input  logic                x_msb_i,
    input  logic                yp_msb_i,
    input  logic [FLAG_ANC-1:0] anc_i,
    output logic                ovf_o,
    output logic                slt_o
);
    logic ovf_line, slt_line;

    always_comb begin
        ovf_line = anc_i[0] ^ carry_msb_in_i;
        ovf_line = ovf_line ^ carry_msb_out_i;
        slt_line = anc_i[1] ^ sign_i;
        slt_line = slt_line ^ ovf_line;
        ovf_o    = ovf_line;
        slt_o    = slt_line;
    end

    always_comb begin
        if (anc_i == '0)
            assert_ovf_sign_R4: assert (ovf_o ==
                ((x_msb_i == yp_msb_i) && (sign_i != x_msb_i)))
                else $error("overflow disagrees with operand signs");
    end
endmodule

// File: rtl/ralu_chain.sv
module ralu_chain
    import ralu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]           x,
    input  logic [WIDTH-1:0]           y,
    input  logic                       as_ctl,
    input  logic                       cin,
    input  logic                       cpn,
    input  logic                       sel1,
    input  logic                       sel2,
    input  logic [SLICE_ANC*WIDTH-1:0] anc_fn,
    input  logic [FLAG_ANC-1:0]        anc_flag,
    output logic [WIDTH-1:0]           result,
    output logic                       cout,
    output logic                       ovf,
    output logic                       slt,
    output logic                       as_out,
    output logic                       cpn_out,
    output logic                       sel1_out,
    output logic                       sel2_out,
    output logic [WIDTH-1:0]           x_out,
    output logic [3*WIDTH-1:0]         garb
);
    localparam int ANC_W = SLICE_ANC * WIDTH;
    localparam int MSB   = WIDTH - 1;

    logic [WIDTH:0]   as_c, cpn_c, s1_c, s2_c, carry;
    logic [WIDTH-1:0] sum;

    assign as_c[0]  = as_ctl;
    assign cpn_c[0] = cpn;
    assign s1_c[0]  = sel1;
    assign s2_c[0]  = sel2;
    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        ralu_slice u_slice (
            .as_i(as_c[i]), .cpn_i(cpn_c[i]), .sel1_i(s1_c[i]), .sel2_i(s2_c[i]),
            .x_i(x[i]), .y_i(y[i]), .cin_i(carry[i]),
            .anc_i(anc_fn[SLICE_ANC*i +: SLICE_ANC]),
            .as_o(as_c[i+1]), .cpn_o(cpn_c[i+1]), .sel1_o(s1_c[i+1]),
            .sel2_o(s2_c[i+1]), .x_o(x_out[i]), .cout_o(carry[i+1]),
            .sum_o(sum[i]), .res_o(result[i]), .garb_o(garb[3*i +: 3])
        );
    end

    ralu_flags u_flags (
        .carry_msb_in_i(carry[MSB]), .carry_msb_out_i(carry[WIDTH]),
        .sign_i(sum[MSB]), .x_msb_i(x[MSB]), .yp_msb_i(y[MSB] ^ as_c[MSB]),
        .anc_i(anc_flag), .ovf_o(ovf), .slt_o(slt)
    );

    assign cout     = carry[WIDTH];
    assign as_out   = as_c[WIDTH];
    assign cpn_out  = cpn_c[WIDTH];
    assign sel1_out = s1_c[WIDTH];
    assign sel2_out = s2_c[WIDTH];

    always_comb begin
        assert_ctl_copies_R6: assert (as_out == as_ctl && cpn_out == cpn &&
                                      sel1_out == sel1 && sel2_out == sel2)
            else $error("control copies corrupted along the chain");
        if (anc_fn == {ANC_W{1'b0}} && sel2 && !sel1)
            assert_sum_route_R3: assert (result == sum)
                else $error("arithmetic code did not route the sum word");
    end
endmodule

// File: tb/test_ralu_chain.sv
module test_ralu_chain;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] x, y, result, x_out;
    logic as_ctl, cin, cpn, sel1, sel2;
    logic [3*W-1:0] anc_fn, garb;
    logic [1:0] anc_flag;
    logic cout, ovf, slt, as_out, cpn_out, sel1_out, sel2_out;

    ralu_chain #(.WIDTH(W)) i_ralu_chain (
        .x(x), .y(y), .as_ctl(as_ctl), .cin(cin), .cpn(cpn), .sel1(sel1),
        .sel2(sel2), .anc_fn(anc_fn), .anc_flag(anc_flag), .result(result),
        .cout(cout), .ovf(ovf), .slt(slt), .as_out(as_out), .cpn_out(cpn_out),
        .sel1_out(sel1_out), .sel2_out(sel2_out), .x_out(x_out), .garb(garb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected candidate value of one bit, from R1/R2/R3/R9.
    function automatic logic cand(input int code, input int i, input logic [W-1:0] a,
                                  input logic [W-1:0] b, input logic s, input logic ci,
                                  input logic p, input logic [3*W-1:0] an);
        logic [W-1:0] bp;
        logic [W:0] low;
        bp = b ^ {W{s}};
        low = {1'b0, a} + {1'b0, bp} + {{W{1'b0}}, ci};
        case (code)
            0: return ~(a[i] & bp[i]) ^ ~p ^ an[3*i];
            1: return (a[i] | bp[i]) ^ p ^ an[3*i+1];
            2: return low[i];
            default: return a[i] ^ bp[i];
        endcase
    endfunction

    task automatic apply_and_check(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic s, input logic ci, input logic p,
                                   input logic [1:0] code, input logic [3*W-1:0] an,
                                   input logic [1:0] af);
        logic [W-1:0] bp, exp_res;
        logic [3*W-1:0] exp_g;
        logic [W:0] full;
        logic [W-1:0] lowsum;
        logic cin_msb, e_ovf, e_slt;
        @(negedge clk);
        x = a; y = b; as_ctl = s; cin = ci; cpn = p;
        {sel2, sel1} = code; anc_fn = an; anc_flag = af;
        #(CLK_PERIOD/4);
        bp = b ^ {W{s}};
        for (int i = 0; i < W; i++) begin
            exp_res[i] = cand(int'(code), i, a, b, s, ci, p, an) ^ an[3*i+2];
            for (int k = 0, m = 0; k < 4; k++)
                if (k != int'(code)) begin
                    exp_g[3*i+m] = cand(k, i, a, b, s, ci, p, an);
                    m++;
                end
        end
        full = {1'b0, a} + {1'b0, bp} + {{W{1'b0}}, ci};
        lowsum = {1'b0, a[W-2:0]} + {1'b0, bp[W-2:0]} + {{(W-1){1'b0}}, ci};
        cin_msb = lowsum[W-1];
        e_ovf = af[0] ^ cin_msb ^ full[W];
        e_slt = af[1] ^ full[W-1] ^ e_ovf;
        check("R1 R2 R9 result", {28'd0, result}, {28'd0, exp_res});
        check("R8 garbage", {20'd0, garb}, {20'd0, exp_g});
        check("R7 x copy", {28'd0, x_out}, {28'd0, a});
        check("R6 controls", {28'd0, as_out, cpn_out, sel1_out, sel2_out},
              {28'd0, s, p, code[0], code[1]});
        if (code == 2'd2) begin
            check("R3 cout", {31'd0, cout}, {31'd0, full[W]});
            check("R4 ovf", {31'd0, ovf}, {31'd0, e_ovf});
            check("R5 slt", {31'd0, slt}, {31'd0, e_slt});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        logic [W:0] sres;
        seed_dummy = $urandom(32'h5a17);
        x = '0; y = '0; as_ctl = 0; cin = 0; cpn = 0; sel1 = 0; sel2 = 0;
        anc_fn = '0; anc_flag = '0;
        @(negedge clk); #(CLK_PERIOD/4);
        // Idle state: all-zero inputs give AND of zeros
        check("R1 idle result", {28'd0, result}, 32'd0);
        check("R6 idle controls", {28'd0, as_out, cpn_out, sel1_out, sel2_out}, 32'd0);
        // R10 line balance
        check("R10 line count",
              $bits(x) + $bits(y) + 5 + $bits(anc_fn) + $bits(anc_flag),
              $bits(result) + 7 + $bits(x_out) + $bits(garb));
        check("R10 line total", $bits(x) + $bits(y) + 5 + $bits(anc_fn) + $bits(anc_flag),
              5*W + 7);
        // Directed corners: most negative / most positive
        apply_and_check(4'h8, 4'h1, 1, 1, 0, 2'd2, '0, '0);   // -8-1 overflows
        check("R4 min minus one", {31'd0, ovf}, 32'd1);
        apply_and_check(4'h7, 4'h1, 0, 0, 0, 2'd2, '0, '0);   // 7+1 overflows
        check("R4 max plus one", {31'd0, ovf}, 32'd1);
        apply_and_check(4'h8, 4'h7, 1, 1, 0, 2'd2, '0, '0);
        check("R5 min less than max", {31'd0, slt}, 32'd1);
        apply_and_check(4'h7, 4'h8, 1, 1, 0, 2'd2, '0, '0);
        check("R5 max not less than min", {31'd0, slt}, 32'd0);
        apply_and_check(4'hF, 4'h1, 0, 0, 0, 2'd2, '0, '0);
        check("R3 wrap cout", {31'd0, cout}, 32'd1);
        // R2: cpn gives NAND/NOR, leaves XOR alone
        apply_and_check(4'hC, 4'hA, 0, 0, 1, 2'd0, '0, '0);
        check("R2 nand", {28'd0, result}, 32'h7);
        apply_and_check(4'hC, 4'hA, 0, 0, 1, 2'd3, '0, '0);
        check("R2 xor unaffected", {28'd0, result}, 32'h6);
        // R9: result seed touches result only
        apply_and_check(4'hC, 4'hA, 0, 0, 0, 2'd3, 12'h004, '0);
        check("R9 result seed", {28'd0, result}, 32'h7);
        // Exhaustive signed subtraction and addition flags
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply_and_check(a[W-1:0], b[W-1:0], 1, 1, 0, 2'd2, '0, '0);
                check("R5 signed less", {31'd0, slt},
                      {31'd0, ($signed(a[W-1:0]) < $signed(b[W-1:0]))});
                apply_and_check(a[W-1:0], b[W-1:0], 0, 0, 0, 2'd2, '0, '0);
                sres = {a[W-1], a[W-1:0]} + {b[W-1], b[W-1:0]};
                check("R4 signed range", {31'd0, ovf}, {31'd0, sres[W] ^ sres[W-1]});
            end
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [3*W-1:0] an;
            logic [1:0] af;
            an = ($urandom % 5 == 0) ? 12'($urandom) : '0;
            af = ($urandom % 5 == 0) ? 2'($urandom) : '0;
            apply_and_check(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                            1'($urandom), 2'($urandom), an, af);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule